// File: doc/BRIEF.md
# Dual-Master Shared-Target Arbiter

This block decides, every cycle, which of two bus masters may use each of a small set of shared slave targets. One master is the processor and the other is a DMA engine. Each reaches the targets over its own bus layer, so the two can work at the same time as long as they address different targets. Only a collision on one target causes a stall, and the processor always wins that collision. Either master may need several cycles for an access. A grant therefore stays in force from the cycle it is first given until the owning master signals completion. A later request cannot take the target away.

The default build has four shared targets: on-chip RAM, the peripheral bus, the external bus and the USB block. A target code equal to or above the number of shared targets means a region that only the processor reaches, such as its instruction flash. That region never collides with DMA traffic, and DMA requests to it are never granted. The outputs are one grant per master, plus per-target select and owner lines that steer each target's multiplexer toward the master holding it.

Top module: `dual_master_target_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both grants, every target select and every owner bit are low.
- R2: Requests from both masters to different shared targets are both granted in the same cycle. The two accesses never hold the same target at once.
- R3: When neither master is mid-access and both request the same shared target in the same cycle, the processor is granted and the DMA is not.
- R4: A stalled DMA request that is held steady is granted in the first cycle after the processor's access to that target completes, provided the processor does not request that target again.
- R5: A processor request cannot take a target from a DMA access in progress. The processor is granted in the cycle after the DMA signals completion.
- R6: A grant stays high, whatever the request input does, from its first cycle through the cycle in which the master's done input is high.
- R7: A processor target code of NUM_TGT or above (code 4 by default, the private flash region) is granted without regard to DMA activity. It drives no target select and never stalls the DMA.
- R8: A DMA target code of NUM_TGT or above is never granted.
- R9: tgt_sel bit i (bit 0 RAM, 1 peripheral bus, 2 external bus, 3 USB) is high exactly when a granted master uses target i. tgt_dma bit i is high exactly when that master is the DMA.
- R10: The target of an access is captured in its first granted cycle. Changes on the target code input during the rest of the access do not change the selects or the conflict decisions.
- R11: An access whose done input is high in its first granted cycle lasts that single cycle. The master is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_tgt | input | 3 | Processor target code (0 RAM, 1 peripheral, 2 external, 3 USB, 4 and above private) |
| cpu_done | input | 1 | Processor access completes this cycle |
| dma_req | input | 1 | DMA request valid |
| dma_tgt | input | 3 | DMA target code |
| dma_done | input | 1 | DMA access completes this cycle |
| cpu_gnt | output | 1 | Processor granted (combinational) |
| dma_gnt | output | 1 | DMA granted (combinational) |
| tgt_sel | output | 4 | Per-target select |
| tgt_dma | output | 4 | Per-target owner: 1 for DMA, 0 for processor |

## Verification
The assertions assume that a master raises done only in a cycle when it holds a grant. They also assume that a stalled DMA request keeps its valid and target code until it is granted. Under these conditions each access has a well-defined start and end. The random stimulus follows both rules: done is drawn only in cycles when the bench's model predicts a grant, and a request that went ungranted is repeated unchanged. While an access is in progress, the target code and request inputs are randomized freely to exercise the capture-at-start behaviour.

// File: rtl/tarb_pkg.sv
package tarb_pkg;
  // Which master a tracker or decision refers to
  typedef enum logic {
    MST_CPU = 1'b0,
    MST_DMA = 1'b1
  } master_e;

  // Default number of shared targets
  localparam int TARB_DEF_TARGETS = 4;
endpackage

// File: rtl/tarb_track.sv
// Per-master access tracker: remembers an access in progress and its target.
module tarb_track
  import tarb_pkg::*;
#(
  parameter master_e WHO   = MST_CPU,
  parameter int      TGT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt,
  input  logic             done,
  input  logic [TGT_W-1:0] tgt_in,
  output logic             busy,
  output logic [TGT_W-1:0] eff_tgt
);
  logic             busy_q, busy_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic             load_en;

  // next state
  always_comb begin
    busy_d  = gnt & ~done;
    load_en = gnt & ~busy_q;
    tgt_d   = tgt_q;
    if (load_en) tgt_d = tgt_in;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (load_en) tgt_q <= tgt_d;
    end
  end

  assign busy    = busy_q;
  assign eff_tgt = busy_q ? tgt_q : tgt_in;

  // WHO only labels the instance
  localparam bit IS_DMA = (WHO == MST_DMA);
  logic unused_who;
  assign unused_who = IS_DMA;
endmodule

// File: rtl/tarb_decide.sv
// Conflict decision: diagonal conflict matrix, processor priority, no preemption.
module tarb_decide #(
  parameter int NUM_TGT = 4,
  parameter int TGT_W   = 3
) (
  input  logic             cpu_req,
  input  logic [TGT_W-1:0] cpu_tgt,
  input  logic             cpu_busy,
  input  logic [TGT_W-1:0] cpu_eff,
  input  logic             dma_req,
  input  logic [TGT_W-1:0] dma_tgt,
  input  logic             dma_busy,
  input  logic [TGT_W-1:0] dma_eff,
  output logic             cpu_gnt,
  output logic             dma_gnt
);
  localparam logic [TGT_W-1:0] SHARED_LIM = TGT_W'(NUM_TGT);

  logic cpu_blocked, cpu_active, dma_blocked, dma_shared;

  always_comb begin
    // the processor waits only for a DMA access already holding its target
    cpu_blocked = dma_busy && (dma_eff == cpu_tgt);
    cpu_gnt     = cpu_busy | (cpu_req & ~cpu_blocked);

    // the DMA yields to any processor activity on the same target
    cpu_active  = cpu_busy | cpu_req;
    dma_shared  = dma_tgt < SHARED_LIM;
    dma_blocked = cpu_active && (cpu_eff == dma_tgt);
    dma_gnt     = dma_busy | (dma_req & dma_shared & ~dma_blocked);
  end
endmodule

// File: rtl/tarb_route.sv
// Per-target select and owner lines.
module tarb_route #(
  parameter int NUM_TGT = 4,
  parameter int TGT_W   = 3
) (
  input  logic               cpu_gnt,
  input  logic [TGT_W-1:0]   cpu_eff,
  input  logic               dma_gnt,
  input  logic [TGT_W-1:0]   dma_eff,
  output logic [NUM_TGT-1:0] tgt_sel,
  output logic [NUM_TGT-1:0] tgt_dma
);
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    logic cpu_hit, dma_hit;
    assign cpu_hit    = cpu_gnt && (cpu_eff == TGT_W'(g));
    assign dma_hit    = dma_gnt && (dma_eff == TGT_W'(g));
    assign tgt_sel[g] = cpu_hit | dma_hit;
    assign tgt_dma[g] = dma_hit;
  end
endmodule

// File: rtl/dual_master_target_arb.sv
module dual_master_target_arb
  import tarb_pkg::*;
#(
  parameter  int NUM_TGT = TARB_DEF_TARGETS,
  localparam int TGT_W   = $clog2(NUM_TGT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic [TGT_W-1:0]   cpu_tgt,
  input  logic               cpu_done,
  input  logic               dma_req,
  input  logic [TGT_W-1:0]   dma_tgt,
  input  logic               dma_done,
  output logic               cpu_gnt,
  output logic               dma_gnt,
  output logic [NUM_TGT-1:0] tgt_sel,
  output logic [NUM_TGT-1:0] tgt_dma
);
  logic             cpu_busy, dma_busy;
  logic [TGT_W-1:0] cpu_eff, dma_eff;

  tarb_track #(.WHO(MST_CPU), .TGT_W(TGT_W)) u_cpu_trk (
    .clk(clk), .rst_n(rst_n), .gnt(cpu_gnt), .done(cpu_done),
    .tgt_in(cpu_tgt), .busy(cpu_busy), .eff_tgt(cpu_eff)
  );

  tarb_track #(.WHO(MST_DMA), .TGT_W(TGT_W)) u_dma_trk (
    .clk(clk), .rst_n(rst_n), .gnt(dma_gnt), .done(dma_done),
    .tgt_in(dma_tgt), .busy(dma_busy), .eff_tgt(dma_eff)
  );

  tarb_decide #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) u_decide (
    .cpu_req(cpu_req), .cpu_tgt(cpu_tgt), .cpu_busy(cpu_busy), .cpu_eff(cpu_eff),
    .dma_req(dma_req), .dma_tgt(dma_tgt), .dma_busy(dma_busy), .dma_eff(dma_eff),
    .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
  );

  tarb_route #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) u_route (
    .cpu_gnt(cpu_gnt), .cpu_eff(cpu_eff), .dma_gnt(dma_gnt), .dma_eff(dma_eff),
    .tgt_sel(tgt_sel), .tgt_dma(tgt_dma)
  );
endmodule

// File: rtl/dual_master_target_arb_chk.sv
module dual_master_target_arb_chk #(
  parameter int NUM_TGT = 4,
  parameter int TGT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic [TGT_W-1:0]   cpu_tgt,
  input logic               cpu_done,
  input logic               dma_req,
  input logic [TGT_W-1:0]   dma_tgt,
  input logic               dma_done,
  input logic               cpu_gnt,
  input logic               dma_gnt,
  input logic [NUM_TGT-1:0] tgt_sel,
  input logic [NUM_TGT-1:0] tgt_dma,
  input logic               cpu_busy,
  input logic               dma_busy,
  input logic [TGT_W-1:0]   cpu_eff,
  input logic [TGT_W-1:0]   dma_eff
);
  localparam logic [TGT_W-1:0] LIM = TGT_W'(NUM_TGT);

  // R1: no grant in the first cycle after reset
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cpu_gnt && !dma_gnt && tgt_sel == '0));

  // R2: the two masters never hold the same target
  p_no_shared_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && dma_gnt) |-> (cpu_eff != dma_eff));

  // R3: processor wins a same-cycle collision
  p_cpu_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && dma_req && !cpu_busy && !dma_busy && cpu_tgt == dma_tgt)
      |-> (cpu_gnt && !dma_gnt));

  // R5: a DMA access in progress keeps its target from the processor
  p_no_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && !dma_done) |=> !(cpu_gnt && cpu_eff == dma_eff));

  // R6: grants hold until done
  p_cpu_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !cpu_done) |=> cpu_gnt);
  p_dma_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && !dma_done) |=> dma_gnt);

  // R7: a private processor access drives no select while the DMA is idle
  p_private_nosel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && cpu_eff >= LIM && !dma_gnt) |-> (tgt_sel == '0));

  // R8: DMA never granted outside the shared targets
  p_dma_shared_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |-> (dma_eff < LIM));

  // R9: a granted DMA access marks its target as DMA owned
  p_dma_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && dma_eff < LIM) |-> (tgt_sel[dma_eff] && tgt_dma[dma_eff]));

  // R10: target stays fixed across an access
  p_cpu_tgt_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !cpu_done) |=> $stable(cpu_eff));
  p_dma_tgt_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && !dma_done) |=> $stable(dma_eff));
endmodule

bind dual_master_target_arb dual_master_target_arb_chk #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req(cpu_req), .cpu_tgt(cpu_tgt), .cpu_done(cpu_done),
  .dma_req(dma_req), .dma_tgt(dma_tgt), .dma_done(dma_done),
  .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .tgt_sel(tgt_sel), .tgt_dma(tgt_dma),
  .cpu_busy(cpu_busy), .dma_busy(dma_busy), .cpu_eff(cpu_eff), .dma_eff(dma_eff)
);

// File: tb/test_dual_master_target_arb.sv
`timescale 1ns/1ps
module test_dual_master_target_arb;
  localparam int NT = 4;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_done, dma_req, dma_done;
  logic [TW-1:0] cpu_tgt, dma_tgt;
  logic          cpu_gnt, dma_gnt;
  logic [NT-1:0] tgt_sel, tgt_dma;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  dual_master_target_arb #(.NUM_TGT(NT)) i_dual_master_target_arb (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_tgt(cpu_tgt), .cpu_done(cpu_done),
    .dma_req(dma_req), .dma_tgt(dma_tgt), .dma_done(dma_done),
    .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .tgt_sel(tgt_sel), .tgt_dma(tgt_dma)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model state
  bit          m_cb, m_db;
  logic [TW-1:0] m_ct, m_dt;

  function automatic logic [TW-1:0] f_ceff();
    return m_cb ? m_ct : cpu_tgt;
  endfunction
  function automatic logic [TW-1:0] f_deff();
    return m_db ? m_dt : dma_tgt;
  endfunction
  function automatic bit f_cg();
    return m_cb || (cpu_req && !(m_db && m_dt == cpu_tgt));
  endfunction
  function automatic bit f_dg();
    return m_db || (dma_req && dma_tgt < TW'(NT) &&
                    !((m_cb || cpu_req) && f_ceff() == dma_tgt));
  endfunction
  function automatic logic [NT-1:0] f_sel(input bit cg, input bit dg);
    logic [NT-1:0] s = '0;
    for (int i = 0; i < NT; i++)
      s[i] = (cg && f_ceff() == TW'(i)) || (dg && f_deff() == TW'(i));
    return s;
  endfunction
  function automatic logic [NT-1:0] f_own(input bit dg);
    logic [NT-1:0] s = '0;
    for (int i = 0; i < NT; i++) s[i] = dg && f_deff() == TW'(i);
    return s;
  endfunction

  task automatic drive_idle();
    cpu_req = 0; cpu_tgt = 0; cpu_done = 0;
    dma_req = 0; dma_tgt = 0; dma_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive_idle();
    rst_n = 0;
    #1;
    chk("R1 cpu_gnt in reset", 32'(cpu_gnt), 0);
    chk("R1 dma_gnt in reset", 32'(dma_gnt), 0);
    chk("R1 tgt_sel in reset", 32'(tgt_sel), 0);
    @(negedge clk);
    rst_n = 1;
    m_cb = 0; m_db = 0; m_ct = 0; m_dt = 0;
  endtask

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit c_pend, d_pend;
    void'($urandom(32'd20240611));
    drive_idle();
    rst_n = 0;
    do_reset();
    #1;
    chk("R1 cpu_gnt after reset", 32'(cpu_gnt), 0);
    chk("R1 tgt_dma after reset", 32'(tgt_dma), 0);

    // R2 + R11: different targets, single-cycle accesses
    @(negedge clk);
    cpu_req = 1; cpu_tgt = 0; cpu_done = 1;
    dma_req = 1; dma_tgt = 3; dma_done = 1;
    #1;
    chk("R2 cpu_gnt", 32'(cpu_gnt), 1);
    chk("R2 dma_gnt", 32'(dma_gnt), 1);
    chk("R9 tgt_sel", 32'(tgt_sel), 32'h9);
    chk("R9 tgt_dma", 32'(tgt_dma), 32'h8);
    @(negedge clk); drive_idle(); #1;
    chk("R11 cpu idle after one-cycle access", 32'(cpu_gnt), 0);
    chk("R11 dma idle after one-cycle access", 32'(dma_gnt), 0);

    // R3, R6, R4: collision on RAM
    @(negedge clk);
    cpu_req = 1; cpu_tgt = 0; dma_req = 1; dma_tgt = 0; #1;
    chk("R3 cpu_gnt", 32'(cpu_gnt), 1);
    chk("R3 dma_gnt", 32'(dma_gnt), 0);
    chk("R3 tgt_dma", 32'(tgt_dma), 0);
    @(negedge clk); cpu_req = 0; #1;
    chk("R6 cpu_gnt held", 32'(cpu_gnt), 1);
    chk("R4 dma stalled", 32'(dma_gnt), 0);
    @(negedge clk); cpu_done = 1; #1;
    chk("R6 cpu_gnt on done", 32'(cpu_gnt), 1);
    chk("R4 dma stalled on done", 32'(dma_gnt), 0);
    @(negedge clk); cpu_done = 0; #1;
    chk("R4 dma granted after cpu done", 32'(dma_gnt), 1);
    chk("R9 dma owns RAM", 32'(tgt_dma), 32'h1);
    dma_done = 1;
    @(negedge clk); drive_idle();

    // R5: DMA in progress on peripheral bus
    @(negedge clk); dma_req = 1; dma_tgt = 1; #1;
    chk("R5 dma start", 32'(dma_gnt), 1);
    @(negedge clk); dma_req = 0; cpu_req = 1; cpu_tgt = 1; #1;
    chk("R5 cpu not granted", 32'(cpu_gnt), 0);
    chk("R5 dma keeps target", 32'(tgt_dma), 32'h2);
    @(negedge clk); dma_done = 1; #1;
    chk("R5 cpu waits through done", 32'(cpu_gnt), 0);
    @(negedge clk); dma_done = 0; #1;
    chk("R5 cpu granted after dma done", 32'(cpu_gnt), 1);
    chk("R5 owner back to cpu", 32'(tgt_dma), 0);
    cpu_done = 1;
    @(negedge clk); drive_idle();

    // R7: private processor region alongside DMA on RAM
    @(negedge clk); cpu_req = 1; cpu_tgt = 4; #1;
    chk("R7 private granted alone", 32'(cpu_gnt), 1);
    chk("R7 private no select", 32'(tgt_sel), 0);
    @(negedge clk); cpu_req = 0; dma_req = 1; dma_tgt = 0; #1;
    chk("R7 cpu still held", 32'(cpu_gnt), 1);
    chk("R7 dma not stalled", 32'(dma_gnt), 1);
    chk("R7 select only RAM", 32'(tgt_sel), 32'h1);
    cpu_done = 1; dma_done = 1;
    @(negedge clk); drive_idle();

    // R8: DMA to private code
    @(negedge clk); dma_req = 1; dma_tgt = 4;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R8 dma private not granted", 32'(dma_gnt), 0);
      chk("R8 no select", 32'(tgt_sel), 0);
      @(negedge clk);
    end
    drive_idle();

    // R10: target captured at start
    @(negedge clk); cpu_req = 1; cpu_tgt = 2; #1;
    chk("R10 cpu start ext", 32'(tgt_sel), 32'h4);
    @(negedge clk); cpu_tgt = 3; dma_req = 1; dma_tgt = 3; #1;
    chk("R10 cpu select unchanged", 32'(tgt_sel), 32'hC);
    chk("R10 dma gets usb", 32'(dma_gnt), 1);
    chk("R10 dma owns usb", 32'(tgt_dma), 32'h8);
    cpu_done = 1; dma_done = 1;
    @(negedge clk); drive_idle();

    // random phase
    do_reset();
    c_pend = 0; d_pend = 0;
    for (int n = 0; n < 4000; n++) begin
      bit cg, dg;
      @(negedge clk);
      cpu_done = 0; dma_done = 0;
      if (!c_pend) begin
        cpu_req = ($urandom % 2) == 0;
        cpu_tgt = TW'($urandom % 6);
      end
      if (!d_pend) begin
        dma_req = ($urandom % 2) == 0;
        dma_tgt = TW'($urandom % NT);
      end
      cg = f_cg(); dg = f_dg();
      cpu_done = cg && ($urandom % 3 == 0);
      dma_done = dg && ($urandom % 3 == 0);
      #1;
      chk("R3 random cpu_gnt", 32'(cpu_gnt), 32'(cg));
      chk("R2 random dma_gnt", 32'(dma_gnt), 32'(dg));
      chk("R9 random tgt_sel", 32'(tgt_sel), 32'(f_sel(cg, dg)));
      chk("R9 random tgt_dma", 32'(tgt_dma), 32'(f_own(dg)));
      c_pend = !m_cb && cpu_req && !cg;
      d_pend = !m_db && dma_req && !dg;
      if (cg && !m_cb) m_ct = cpu_tgt;
      if (dg && !m_db) m_dt = dma_tgt;
      m_cb = cg && !cpu_done;
      m_db = dg && !dma_done;
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule